// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block keeps the pending-interrupt flags and the per-source enable mask for one 16-bit timer/counter. The timer has four interrupt sources: overflow, compare channel A, compare channel B and input capture. The counter core feeds the block single-cycle event strobes. A clock-enable input, `tick_en`, marks the system clocks on which a prescaled timer tick takes place. The block turns each strobe into a sticky flag and drives one interrupt request per source. A request is high when its flag is set, its mask bit is set and the global interrupt-enable input is high.

Software reaches the block through a small register port with one address bit. Address 0 selects the flag register and address 1 selects the mask register. A flag is cleared in one of two ways: software writes a one to its bit, or the vectoring logic pulses that source's acknowledge line. How the capture flag is set depends on the waveform mode. In the normal mode the capture input edge sets it. When the capture register serves as TOP, the counter reaching TOP sets it instead. A compare flag is set one timer tick after its match. A match that comes with a forced-compare strobe never sets its flag.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset every flag and every mask bit is zero, both registers read 0x00, and all `irq` outputs are low.
- R2: The flag register (`reg_addr`=0) reads the capture flag at bit 5, the compare-B flag at bit 2, the compare-A flag at bit 1 and the overflow flag at bit 0. Every other bit reads zero.
- R3: Writing the mask register (`reg_addr`=1) stores bits 5, 2, 1 and 0 as the enables for capture, compare B, compare A and overflow. Reading it back returns those bits and zero in all other positions.
- R4: `irq` is indexed as [0] overflow, [1] compare A, [2] compare B, [3] capture. Each bit is high exactly when that source's flag, that source's mask bit and `gie` are all one.
- R5: With `cap_is_top`=0, a `cap_edge` strobe on any system clock sets the capture flag whatever the value of `tick_en`. `cnt_at_top` has no effect on the flag.
- R6: With `cap_is_top`=1, the capture flag is set only by `cnt_at_top` on a cycle with `tick_en`=1. `cap_edge` is ignored.
- R7: A compare match seen on a tick sets its flag at the next tick, not at the matching tick. Cycles with `tick_en`=0 between the two ticks do not count.
- R8: A compare match that arrives on the same tick as that channel's forced-compare strobe never sets the flag.
- R9: `ovf_evt` sets the overflow flag only on a cycle with `tick_en`=1.
- R10: Writing the flag register clears each flag whose bit is one in the write data. Flags whose bits are zero in the write data keep their value.
- R11: An `ack` pulse clears only the flag of the source whose acknowledge line is high.
- R12: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | High on system clocks that carry a prescaled timer tick |
| cap_edge | input | 1 | Capture input edge strobe |
| cnt_at_top | input | 1 | Counter equals TOP |
| cmpa_match | input | 1 | Counter equals compare register A |
| cmpb_match | input | 1 | Counter equals compare register B |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| ovf_evt | input | 1 | Counter overflow strobe |
| cap_is_top | input | 1 | Mode: capture register serves as TOP |
| gie | input | 1 | Global interrupt enable |
| reg_addr | input | 1 | 0 = flag register, 1 = mask register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ack | input | 4 | Vector acknowledge per source, same index as `irq` |
| irq | output | 4 | Interrupt request per source |

## Verification
The request gating is swept over all 16 flag patterns, all 16 mask patterns and both values of `gie`. Any crossed source index, wrong register bit position or missing gate term therefore shows up as one specific wrong combination. The timing tests spread `tick_en`-low gaps between a compare match and the next tick. This separates counting timer ticks from counting system clocks, and it separates a one-tick delay from a zero-tick delay. Paired stimuli then drive each capture source in each mode, a match alongside a force strobe, a write with a mixed one/zero pattern, a single acknowledge, and a set that collides with a clear. Each of these tells the intended source, bit or priority apart from its neighbours.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;

  localparam int NSRC  = 4;
  localparam int NCMP  = 2;
  localparam int REG_W = 8;

  // Source indices used on set/clear/ack/irq vectors
  localparam int IDX_OVF  = 0;
  localparam int IDX_CMPA = 1;
  localparam int IDX_CMPB = 2;
  localparam int IDX_CAP  = 3;

  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  // Register bit position of each source
  function automatic int src_pos(input int idx);
    case (idx)
      IDX_OVF:  return 0;
      IDX_CMPA: return 1;
      IDX_CMPB: return 2;
      default:  return 5;
    endcase
  endfunction

  // Source vector -> register image, unused bits zero
  function automatic logic [REG_W-1:0] pack_bits(input logic [NSRC-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[src_pos(i)] = v[i];
    return r;
  endfunction

  // Register image -> source vector
  function automatic logic [NSRC-1:0] unpack_bits(input logic [REG_W-1:0] d);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = d[src_pos(i)];
    return v;
  endfunction

  // Sticky flag update: set dominates clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Capture flag source selection by mode
  function automatic logic cap_source(input logic top_mode, input logic tick,
                                      input logic at_top, input logic edge_s);
    return top_mode ? (tick & at_top) : edge_s;
  endfunction

endpackage

// File: rtl/tmr_irq_evt.sv
`timescale 1ns/1ps
module tmr_irq_evt
  import tmr_irq_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int N_CMP = NCMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cap_edge,
  input  logic             cnt_at_top,
  input  logic [N_CMP-1:0] cmp_match,
  input  logic [N_CMP-1:0] cmp_force,
  input  logic             ovf_evt,
  input  logic             cap_is_top,
  output logic [N_SRC-1:0] set_vec
);

  logic [N_CMP-1:0] cmp_set;

  // One pending stage per compare channel, advanced on timer ticks only
  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (tick_en) pend_q <= cmp_match[c] & ~cmp_force[c];
    end
    assign cmp_set[c] = tick_en & pend_q;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_OVF]  = tick_en & ovf_evt;
    set_vec[IDX_CMPA] = cmp_set[0];
    set_vec[IDX_CMPB] = cmp_set[1];
    set_vec[IDX_CAP]  = cap_source(cap_is_top, tick_en, cnt_at_top, cap_edge);
  end

endmodule

// File: rtl/tmr_irq_flags.sv
`timescale 1ns/1ps
module tmr_irq_flags
  import tmr_irq_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] flag_q
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= flag_next(f_q, set_vec[i], clr_vec[i]);
    end
    assign flag_q[i] = f_q;
  end

endmodule

// File: rtl/tmr_irq_regs.sv
`timescale 1ns/1ps
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int N_SRC = NSRC,
  parameter int DW    = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [N_SRC-1:0] ack,
  input  logic [N_SRC-1:0] flag_q,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] clr_vec,
  output logic [DW-1:0]    reg_rdata
);

  logic wr_flag, wr_mask;
  logic [N_SRC-1:0] wr_bits;

  assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
  assign wr_mask = reg_wr && (reg_addr == ADDR_MASK);
  assign wr_bits = unpack_bits(reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_mask) en_q <= wr_bits;
  end

  assign clr_vec   = ack | (wr_flag ? wr_bits : '0);
  assign reg_rdata = (reg_addr == ADDR_MASK) ? pack_bits(en_q) : pack_bits(flag_q);

endmodule

// File: rtl/tmr_irq_unit.sv
`timescale 1ns/1ps
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cap_edge,
  input  logic             cnt_at_top,
  input  logic             cmpa_match,
  input  logic             cmpb_match,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             ovf_evt,
  input  logic             cap_is_top,
  input  logic             gie,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]  ack,
  output logic [NSRC-1:0]  irq
);

  // Named internal events, observed by the bound checker
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_q;

  tmr_irq_evt #(.N_SRC(NSRC), .N_CMP(NCMP)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cap_edge   (cap_edge),
    .cnt_at_top (cnt_at_top),
    .cmp_match  ({cmpb_match, cmpa_match}),
    .cmp_force  ({force_b, force_a}),
    .ovf_evt    (ovf_evt),
    .cap_is_top (cap_is_top),
    .set_vec    (set_vec)
  );

  tmr_irq_flags #(.N_SRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q)
  );

  tmr_irq_regs #(.N_SRC(NSRC), .DW(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .ack       (ack),
    .flag_q    (flag_q),
    .en_q      (en_q),
    .clr_vec   (clr_vec),
    .reg_rdata (reg_rdata)
  );

  assign irq = flag_q & en_q & {NSRC{gie}};

endmodule

// File: rtl/tmr_irq_chk.sv
`timescale 1ns/1ps
module tmr_irq_chk
  import tmr_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cap_edge,
  input logic             cap_is_top,
  input logic             ovf_evt,
  input logic             gie,
  input logic [REG_W-1:0] reg_rdata,
  input logic [NSRC-1:0]  irq,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  clr_vec
);

  localparam logic [REG_W-1:0] RSVD = ~pack_bits({NSRC{1'b1}});

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSVD) == '0);

  p_irq_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq == '0);

  p_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(flag_q & en_q)) == '0);

  p_cap_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_is_top && cap_edge) |-> set_vec[IDX_CAP]);

  p_cap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_is_top && !tick_en) |-> !set_vec[IDX_CAP]);

  p_cmp_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[IDX_CMPA] || set_vec[IDX_CMPB]) |-> tick_en);

  p_ovf_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[IDX_OVF] |-> (tick_en && ovf_evt));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));
  end

endmodule

bind tmr_irq_unit tmr_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .cap_edge   (cap_edge),
  .cap_is_top (cap_is_top),
  .ovf_evt    (ovf_evt),
  .gie        (gie),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec)
);

// File: tb/tmr_irq_unit_bench.sv
`timescale 1ns/1ps
module tmr_irq_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 0, cap_edge = 0, cnt_at_top = 0;
  logic       cmpa_match = 0, cmpb_match = 0, force_a = 0, force_b = 0;
  logic       ovf_evt = 0, cap_is_top = 0, gie = 0;
  logic       reg_addr = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [3:0] ack = 0;
  logic [3:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_unit u_tmr_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_edge(cap_edge),
    .cnt_at_top(cnt_at_top), .cmpa_match(cmpa_match), .cmpb_match(cmpb_match),
    .force_a(force_a), .force_b(force_b), .ovf_evt(ovf_evt),
    .cap_is_top(cap_is_top), .gie(gie), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .irq(irq)
  );

  // Source index -> register image: ovf b0, A b1, B b2, cap b5
  function automatic logic [7:0] img(input logic [3:0] v);
    return {2'b00, v[3], 2'b00, v[2], v[1], v[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic idle();
    tick_en = 0; cap_edge = 0; cnt_at_top = 0; cmpa_match = 0; cmpb_match = 0;
    force_a = 0; force_b = 0; ovf_evt = 0; reg_wr = 0; ack = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; cyc(); reg_wr = 0;
  endtask

  task automatic make_flags(input logic [3:0] f);
    wr(1'b0, 8'hFF);
    tick_en = 1; ovf_evt = f[0]; cmpa_match = f[1]; cmpb_match = f[2]; cap_edge = f[3];
    cyc();
    idle(); tick_en = 1; cyc();
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(); cyc();
    // R1: reset state
    rd(1'b0, d); chk(d == 8'h00, "R1 flag reg", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R1 mask reg", d, 0);
    gie = 1; #1 chk(irq == 4'h0, "R1 irq", irq, 0); gie = 0;
    rst_n = 1; cyc();

    // R3: mask positions and reserved bits
    wr(1'b1, 8'hFF); rd(1'b1, d); chk(d == 8'h27, "R3 mask all ones", d, 8'h27);
    wr(1'b1, 8'hD8); rd(1'b1, d); chk(d == 8'h00, "R3 mask reserved only", d, 0);

    // R2/R4: sweep flags x enables x gie
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        wr(1'b1, img(4'(e)));
        make_flags(4'(f));
        rd(1'b0, d);
        chk(d == img(4'(f)), "R2 flag layout", d, img(4'(f)));
        gie = 0; #1 chk(irq == 4'h0, "R4 gie off", irq, 0);
        gie = 1; #1 chk(irq == 4'(f & e), "R4 gated irq", irq, f & e);
        gie = 0;
      end
    end

    // R7: compare delay counted in ticks
    wr(1'b1, 8'h00); wr(1'b0, 8'hFF);
    tick_en = 1; cmpa_match = 1; cyc(); idle();
    rd(1'b0, d); chk(d[1] == 1'b0, "R7 not same tick", d, 0);
    cyc(); cyc(); cyc();
    rd(1'b0, d); chk(d[1] == 1'b0, "R7 gaps not ticks", d, 0);
    tick_en = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h02, "R7 next tick sets A", d, 8'h02);
    wr(1'b0, 8'hFF);
    tick_en = 1; cmpb_match = 1; cyc(); idle(); cyc();
    tick_en = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h04, "R7 next tick sets B", d, 8'h04);

    // R8: forced compare suppresses flag
    wr(1'b0, 8'hFF);
    tick_en = 1; cmpa_match = 1; force_a = 1; cmpb_match = 1; force_b = 1; cyc();
    idle(); tick_en = 1; cyc(); idle(); tick_en = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h00, "R8 forced no flag", d, 0);

    // R9: overflow needs tick
    ovf_evt = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h00, "R9 ovf without tick", d, 0);
    tick_en = 1; ovf_evt = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h01, "R9 ovf with tick", d, 8'h01);

    // R5: normal capture mode
    wr(1'b0, 8'hFF); cap_is_top = 0;
    tick_en = 1; cnt_at_top = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h00, "R5 top ignored", d, 0);
    cap_edge = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h20, "R5 edge sets cap", d, 8'h20);

    // R6: capture register as TOP
    wr(1'b0, 8'hFF); cap_is_top = 1;
    cap_edge = 1; tick_en = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h00, "R6 edge ignored", d, 0);
    cnt_at_top = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h00, "R6 top without tick", d, 0);
    cnt_at_top = 1; tick_en = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h20, "R6 top sets cap", d, 8'h20);
    cap_is_top = 0;

    // R10: write-one clear
    make_flags(4'hF);
    wr(1'b0, 8'h00); rd(1'b0, d); chk(d == 8'h27, "R10 zero write keeps", d, 8'h27);
    wr(1'b0, 8'h02); rd(1'b0, d); chk(d == 8'h25, "R10 clear A only", d, 8'h25);
    wr(1'b0, 8'h20); rd(1'b0, d); chk(d == 8'h05, "R10 clear cap only", d, 8'h05);

    // R11: acknowledge clears its own flag
    make_flags(4'hF);
    ack = 4'b0100; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h23, "R11 ack B", d, 8'h23);
    ack = 4'b0001; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h22, "R11 ack ovf", d, 8'h22);

    // R12: set beats clear
    wr(1'b0, 8'hFF);
    tick_en = 1; ovf_evt = 1; reg_addr = 0; reg_wdata = 8'h01; reg_wr = 1; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h01, "R12 set vs write", d, 8'h01);
    cap_edge = 1; ack = 4'b1000; cyc(); idle();
    rd(1'b0, d); chk(d == 8'h21, "R12 set vs ack", d, 8'h21);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule